// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides, during the address phase of a two-wire serial transfer in which the device is the target, whether the device should acknowledge. It watches a stream of received bytes, delivered one at a time with a one-cycle valid strobe. A start-condition pulse from the bit-level receiver separates transfers. The block compares the received address with the device's own address and produces a registered acknowledge decision for each byte it evaluates.

Both 7-bit and 10-bit addressing are supported. A per-bit don't-care mask widens the set of addresses that match. An exact-compare input disables the mask. A fixed set of reserved addresses is never acknowledged, whatever the mask says. The general-call address is acknowledged only when general calls are enabled. In 10-bit mode, the block first matches the header byte, which carries address bits 9:8. It then compares the following byte with the low eight address bits. The read/write bit of the first byte is captured and presented on an output.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: In 7-bit mode, bits 7:1 of the first byte after a start are compared with own address bits 6:0. Any position whose mask bit is 1 is ignored. On a hit, `ack_o` and `match_o` are 1 in the cycle after the strobe.
- R2: While `exact_i` is 1, the mask has no effect, and every address bit must equal the own address.
- R3: A first byte of 0x00 (address 0, write) is a general call. It sets `ack_o`, `match_o` and `gcall_o` only when `gc_en_i` is 1, whatever the mask or own address. When `gc_en_i` is 0 it gives no acknowledge.
- R4: First bytes whose 7-bit address field is reserved are never acknowledged, even when the mask would make them match. The reserved fields are 0000000 with R/W=1, 0000001 to 0000111, and 11111xx.
- R5: In 7-bit mode, a first byte whose address field is 11110xx is never acknowledged.
- R6: In 10-bit mode, a first byte 11110 b9 b8 R/W acknowledges when b9:b8 match own address bits 9:8 under mask bits 9:8. It then sets `hi10_o` and `ack_o`, but not `match_o`. The next byte is compared with own bits 7:0 under mask bits 7:0. `ack_o` and `match_o` follow that result, one cycle after its strobe.
- R7: `rw_o` holds bit 0 of the first byte after a start, from the cycle after its strobe.
- R8: A start pulse clears `ack_o`, `match_o`, `gcall_o`, `hi10_o` and `rw_o` in the next cycle and restarts the address sequence. A byte strobed in the same cycle as a start is dropped.
- R9: Once the address phase has been decided, further bytes leave all outputs unchanged until the next start.
- R10: While the synchronous active-high reset is asserted, every output is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse on a start or repeated start |
| byte_vld_i | input | 1 | One-cycle strobe: `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| own_addr_i | input | 10 | Own address; bits 6:0 in 7-bit mode, all 10 in 10-bit mode |
| mask_i | input | 10 | Don't-care mask, 1 ignores the bit |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | 1 enables acknowledge of the general call |
| exact_i | input | 1 | 1 ignores the mask |
| ack_o | output | 1 | Acknowledge decision for the last evaluated byte |
| match_o | output | 1 | Full address matched in this transfer |
| gcall_o | output | 1 | General call accepted |
| hi10_o | output | 1 | 10-bit header byte matched |
| rw_o | output | 1 | Captured read/write bit |

## Verification
Every decision is due exactly one clock after the strobe or start that causes it, because each output passes through a single register stage. The bench drives each strobe or start for one cycle between falling edges. It samples the five outputs together at the falling edge that ends that cycle, half a period after the register updates. For 10-bit transfers, it checks the header result before sending the low byte, so both stages are seen. Hold behaviour is checked by sending extra bytes and sampling again one cycle later.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_LOW   = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;
endpackage

// File: rtl/i2c_am_classify.sv
module i2c_am_classify #(
  parameter int A7_W = 7
) (
  input  logic [A7_W-1:0] addr_i,
  input  logic            rw_i,
  output logic            gcall_o,
  output logic            reserved_o,
  output logic            hdr10_o
);
  localparam int TOP_W = A7_W - 2;

  logic zero_top4;
  logic ones_top5;

  always_comb begin
    zero_top4  = (addr_i[A7_W-1 -: 4] == 4'b0000);
    ones_top5  = (addr_i[A7_W-1 -: TOP_W] == {TOP_W{1'b1}});
    gcall_o    = (addr_i == '0) && !rw_i;
    hdr10_o    = (addr_i[A7_W-1 -: TOP_W] == {{(TOP_W-1){1'b1}}, 1'b0});
    reserved_o = (zero_top4 && !gcall_o) || ones_top5;
  end
endmodule

// File: rtl/i2c_am_masked_cmp.sv
module i2c_am_masked_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] own_i,
  input  logic [W-1:0] mask_i,
  input  logic         exact_i,
  output logic         hit_o
);
  logic [W-1:0] care;

  always_comb begin
    care  = exact_i ? {W{1'b1}} : ~mask_i;
    hit_o = (((rx_i ^ own_i) & care) == '0);
  end
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  input  logic              exact_i,
  output logic              ack_o,
  output logic              match_o,
  output logic              gcall_o,
  output logic              hi10_o,
  output logic              rw_o
);
  localparam int A7_W = BYTE_W - 1;
  localparam int HI_W = ADDR_W - BYTE_W;

  phase_e          phase_q;
  logic [A7_W-1:0] rx_addr;
  logic            rx_rw;
  logic            is_gc, is_rsv, is_hdr;
  logic            hit7, hit_hi, hit_lo;

  assign rx_addr = byte_i[BYTE_W-1:1];
  assign rx_rw   = byte_i[0];

  i2c_am_classify #(.A7_W(A7_W)) u_cls (
    .addr_i     (rx_addr),
    .rw_i       (rx_rw),
    .gcall_o    (is_gc),
    .reserved_o (is_rsv),
    .hdr10_o    (is_hdr)
  );

  i2c_am_masked_cmp #(.W(A7_W)) u_cmp7 (
    .rx_i    (rx_addr),
    .own_i   (own_addr_i[A7_W-1:0]),
    .mask_i  (mask_i[A7_W-1:0]),
    .exact_i (exact_i),
    .hit_o   (hit7)
  );

  i2c_am_masked_cmp #(.W(HI_W)) u_cmp_hi (
    .rx_i    (rx_addr[HI_W-1:0]),
    .own_i   (own_addr_i[ADDR_W-1:BYTE_W]),
    .mask_i  (mask_i[ADDR_W-1:BYTE_W]),
    .exact_i (exact_i),
    .hit_o   (hit_hi)
  );

  i2c_am_masked_cmp #(.W(BYTE_W)) u_cmp_lo (
    .rx_i    (byte_i),
    .own_i   (own_addr_i[BYTE_W-1:0]),
    .mask_i  (mask_i[BYTE_W-1:0]),
    .exact_i (exact_i),
    .hit_o   (hit_lo)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      phase_q <= PH_FIRST;
      ack_o   <= 1'b0;
      match_o <= 1'b0;
      gcall_o <= 1'b0;
      hi10_o  <= 1'b0;
      rw_o    <= 1'b0;
    end else if (byte_vld_i) begin
      case (phase_q)
        PH_FIRST: begin
          rw_o    <= rx_rw;
          phase_q <= PH_DONE;
          ack_o   <= 1'b0;
          match_o <= 1'b0;
          gcall_o <= 1'b0;
          hi10_o  <= 1'b0;
          if (is_gc) begin
            ack_o   <= gc_en_i;
            match_o <= gc_en_i;
            gcall_o <= gc_en_i;
          end else if (ten_bit_i) begin
            if (is_hdr && hit_hi) begin
              ack_o   <= 1'b1;
              hi10_o  <= 1'b1;
              phase_q <= PH_LOW;
            end
          end else if (!is_rsv && !is_hdr && hit7) begin
            ack_o   <= 1'b1;
            match_o <= 1'b1;
          end
        end
        PH_LOW: begin
          ack_o   <= hit_lo;
          match_o <= hit_lo;
          phase_q <= PH_DONE;
        end
        default: begin
        end
      endcase
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !ack_o && !match_o && !gcall_o && !hi10_o && !rw_o);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !ack_o && !match_o && !gcall_o && !hi10_o && !rw_o);

  assert_reserved_no_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_vld_i && !start_i && phase_q == PH_FIRST && is_rsv) |=> !ack_o);

  assert_gcall_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(gcall_o) |-> $past(gc_en_i));

  assert_ten_bit_order_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_o) && $past(phase_q) == PH_LOW) |-> hi10_o);

  assert_hold_after_decision_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE && !start_i) |=> $stable(match_o) && $stable(ack_o) && $stable(rw_o));
endmodule

// File: tb/i2c_slave_addr_match_bench.sv
module i2c_slave_addr_match_bench;
  logic       clk = 1'b0;
  logic       rst, start_i, byte_vld_i, ten_bit_i, gc_en_i, exact_i;
  logic [7:0] byte_i;
  logic [9:0] own_addr_i, mask_i;
  logic       ack_o, match_o, gcall_o, hi10_o, rw_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  i2c_slave_addr_match u_i2c_slave_addr_match (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .own_addr_i(own_addr_i), .mask_i(mask_i),
    .ten_bit_i(ten_bit_i), .gc_en_i(gc_en_i), .exact_i(exact_i),
    .ack_o(ack_o), .match_o(match_o), .gcall_o(gcall_o),
    .hi10_o(hi10_o), .rw_o(rw_o)
  );

  // expected order: {ack, match, gcall, hi10, rw}
  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {ack_o, match_o, gcall_o, hi10_o, rw_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ack,match,gcall,hi10,rw} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic t_reset_R10();
    rst = 1'b1; start_i = 0; byte_vld_i = 0; byte_i = 0;
    own_addr_i = 10'h02A; mask_i = 0; ten_bit_i = 0; gc_en_i = 0; exact_i = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset", 5'b00000);
    rst = 1'b0;
    restart(); send(8'h54);
    chk("R1 setup before reset", 5'b11000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 mid-run reset", 5'b00000);
  endtask

  task automatic t_seven_bit_R1();
    own_addr_i = 10'h02A; mask_i = 0;
    restart(); send(8'h54); chk("R1 exact hit", 5'b11000);
    restart(); send(8'h56); chk("R1 miss", 5'b00000);
    restart(); send(8'h55); chk("R7 read bit", 5'b11001);
  endtask

  task automatic t_hold_R9();
    restart(); send(8'h54); send(8'h00); chk("R9 hold after match", 5'b11000);
    restart(); send(8'h56); send(8'h54); chk("R9 ignore after miss", 5'b00000);
  endtask

  task automatic t_mask_R2();
    own_addr_i = 0; mask_i = 10'h020;
    restart(); send(8'h40); chk("R1 masked hit", 5'b11000);
    exact_i = 1'b1;
    restart(); send(8'h40); chk("R2 exact ignores mask", 5'b00000);
    exact_i = 1'b0;
  endtask

  task automatic t_gcall_R3();
    own_addr_i = 10'h010; mask_i = 10'h07F; gc_en_i = 1'b0;
    restart(); send(8'h00); chk("R3 gcall disabled", 5'b00000);
    gc_en_i = 1'b1;
    restart(); send(8'h00); chk("R3 gcall enabled", 5'b11100);
  endtask

  task automatic t_reserved_R4();
    own_addr_i = 10'h010; mask_i = 10'h07F; gc_en_i = 1'b1;
    restart(); send(8'h01); chk("R4 start byte", 5'b00001);
    restart(); send(8'h02); chk("R4 addr 0000001", 5'b00000);
    restart(); send(8'h0A); chk("R4 addr 0000101", 5'b00000);
    restart(); send(8'hFE); chk("R4 addr 1111111", 5'b00000);
    restart(); send(8'h20); chk("R1 full mask control", 5'b11000);
    restart(); send(8'hF0); chk("R5 header in 7-bit", 5'b00000);
    gc_en_i = 1'b0;
  endtask

  task automatic t_ten_bit_R6();
    ten_bit_i = 1'b1; own_addr_i = 10'h2A5; mask_i = 0;
    restart(); send(8'hF4); chk("R6 header", 5'b10010);
    send(8'hA5); chk("R6 low byte", 5'b11010);
    restart(); chk("R8 start clears", 5'b00000);
    send(8'hF4); send(8'hA4); chk("R6 low miss", 5'b00010);
    restart(); send(8'hF2); chk("R6 header miss", 5'b00000);
    mask_i = 10'h00F;
    restart(); send(8'hF4); send(8'hAA); chk("R6 masked low", 5'b11010);
    mask_i = 10'h300;
    restart(); send(8'hF0); chk("R6 masked upper", 5'b10010);
    mask_i = 0;
    restart(); send(8'hF4); restart(); send(8'hA5);
    chk("R8 restart mid sequence", 5'b00001);
    ten_bit_i = 1'b0;
  endtask

  task automatic t_start_collide_R8();
    own_addr_i = 10'h02A; mask_i = 0;
    restart(); send(8'h54);
    @(negedge clk); start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h54;
    @(negedge clk); start_i = 1'b0; byte_vld_i = 1'b0;
    chk("R8 byte with start dropped", 5'b00000);
  endtask

  initial begin
    t_reset_R10();
    t_seven_bit_R1();
    t_hold_R9();
    t_mask_R2();
    t_gcall_R3();
    t_reserved_R4();
    t_ten_bit_R6();
    t_start_collide_R8();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule